// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

This block gathers a set of peripheral request lines and one 4-bit encoded external level. It picks a single interrupt to offer the processor. Each peripheral source takes a 4-bit priority from a packed field in a priority register. The field is widened to a 5-bit internal priority by a left shift. A field of zero disables the source. A per-source mask bit, set and cleared through separate addresses, must also be on before a request can become pending.

The external level input drives fifteen virtual sources with fixed priorities 15 down to 1. When the level changes, only the member that matches the new level is asserted.

On every clock the controller scans all pending sources and keeps the highest internal priority. On a tie, the lowest index wins. It halves the winner's priority back to four bits and offers the interrupt only when that value exceeds the processor's current mask level. The offer is the source index as a vector, plus the 4-bit level. A control register sits at address 0. When its level-mode bit is set, a one-cycle acknowledge clears the asserted state of the accepted source.

Top module: `prio_intc`

## Requirements
- R1: After synchronous reset, `irq_valid` is 0 and every register reads as 0.
- R2: Address 0 holds a 32-bit control register that reads back all bits written. Bit 21 is the level-mode enable.
- R3: Priority register r sits at address 1+r and holds four 4-bit fields. Source 4r+k uses bits [15-4k:12-4k], so slot 0 is the most significant nibble. Reads return the low 16 bits written, with the upper 16 bits as 0.
- R4: A write to the mask-set address (number of priority registers + 1) sets every mask bit whose write-data bit is 1. A write to the mask-clear address (one higher) clears every mask bit whose write-data bit is 1. Both addresses read back the mask. Bit i enables source i.
- R5: A peripheral source is pending only when its request is high, its mask bit is 1, and its priority field is nonzero. A field of zero disables it.
- R6: Arbitration picks the pending source with the highest internal priority. For a peripheral this is field×2; for external member j it is (15−j)×2. On equal priority the lowest index wins. Peripherals are indices 0..N−1, and external members are N..N+14.
- R7: An interrupt is offered only when the winner's internal priority shifted right by one is strictly greater than `cpu_mask`. A mask of 15 blocks everything.
- R8: `irq_vector` gives the winner's index and `irq_level` its 4-bit priority. The outputs follow a change on a request, external level, mask input or register one clock later.
- R9: External level 0 means no request, 1 is the lowest level and 15 the highest. When the level changes to L>0, member 15−L (index N+15−L) becomes asserted and all other members are deasserted. A change to 0 deasserts all members. External members need no enable.
- R10: In level mode, an `irq_ack` while `irq_valid` is high clears the asserted state of the presented source. A peripheral then stays clear until its request falls and rises again. An external member stays clear until the level changes. With level mode off, acknowledge changes nothing.
- R11: `irq_ack` while `irq_valid` is low has no effect, even in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | AW (4) | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| src_req | input | NUM_SRC (8) | Peripheral request lines, high = requesting |
| ext_level | input | 4 | Encoded external interrupt level |
| cpu_mask | input | 4 | Processor's current mask level |
| irq_ack | input | 1 | One-cycle acceptance of the offered interrupt |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vector | output | IDW (5) | Index of the offered source |
| irq_level | output | 4 | Priority of the offered source |

## Verification
The bench goes after ties between equal fields: a scan that kept the later source would present index 7 where 5 is expected. It sets the mask equal to the winner's level. A compare written with greater-or-equal would then offer an interrupt that must stay blocked. It also acknowledges in level mode while a request stays high, and acknowledges while nothing is offered. A design that re-asserted on level rather than on a fresh edge would offer the source again at once. A design that obeyed an acknowledge with no valid offer would silently lose a masked request. A reversed nibble order or a wrong external-member mapping shows up as the wrong vector.

// File: rtl/intc_pkg.sv
// Package: shared constants and helpers for the priority interrupt controller.
// Assumes 4-bit programmed priorities and a 15-member external group.
package intc_pkg;
    localparam int EXT_MEMBERS  = 15;
    localparam int PW           = 5;   // internal priority width
    localparam int LVL_MODE_BIT = 21;

    // Widen a programmed 4-bit field to the 5-bit internal priority.
    function automatic logic [PW-1:0] widen_prio(input logic [3:0] field);
        return {field, 1'b0};
    endfunction

    // Internal priority of external member j (member 0 is the highest).
    function automatic logic [PW-1:0] ext_prio(input int j);
        return PW'((EXT_MEMBERS - j) * 2);
    endfunction
endpackage

// File: rtl/intc_regfile.sv
// Register file: control word, packed priority registers, and a mask
// with set/clear addresses. Assumes NUM_SRC <= 32; reads are combinational.
module intc_regfile #(
    parameter int NUM_SRC = 8,
    parameter int AW      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        reg_addr,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 lvl_mode,
    output logic [NUM_SRC*4-1:0] prio_field,
    output logic [NUM_SRC-1:0]   mask_q
);
    localparam int NPR       = (NUM_SRC + 3) / 4;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_SET  = NPR + 1;
    localparam int ADDR_CLR  = NPR + 2;

    logic [31:0] ctrl_q;
    logic [15:0] prio_q [NPR];

    // Control register: plain 32-bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (reg_wr && reg_addr == AW'(ADDR_CTRL))
            ctrl_q <= reg_wdata;
    end

    assign lvl_mode = ctrl_q[intc_pkg::LVL_MODE_BIT];

    // One storage process per priority register.
    for (genvar r = 0; r < NPR; r++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[r] <= '0;
            else if (reg_wr && reg_addr == AW'(r + 1))
                prio_q[r] <= reg_wdata[15:0];
        end
    end

    // Field extraction: slot 0 is the most significant nibble.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
        assign prio_field[s*4 +: 4] = prio_q[s/4][15-4*(s%4) -: 4];
    end

    // Mask register with separate set and clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_wr && reg_addr == AW'(ADDR_SET))
            mask_q <= mask_q | reg_wdata[NUM_SRC-1:0];
        else if (reg_wr && reg_addr == AW'(ADDR_CLR))
            mask_q <= mask_q & ~reg_wdata[NUM_SRC-1:0];
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADDR_CTRL))
            reg_rdata = ctrl_q;
        for (int r = 0; r < NPR; r++)
            if (reg_addr == AW'(r + 1))
                reg_rdata = {16'h0000, prio_q[r]};
        if (reg_addr == AW'(ADDR_SET) || reg_addr == AW'(ADDR_CLR))
            reg_rdata = 32'(mask_q);
    end

    assert_ctrl_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == AW'(ADDR_CTRL)) |=> $stable(ctrl_q));

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(ADDR_SET)) |=>
        ((mask_q & $past(reg_wdata[NUM_SRC-1:0])) == $past(reg_wdata[NUM_SRC-1:0])));
endmodule

// File: rtl/intc_req_track.sv
// Peripheral request tracker: a source becomes asserted on a rising request.
// It stays asserted while the request is high, unless a level-mode clear hits it.
module intc_req_track #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] asrt_q
);
    logic [NUM_SRC-1:0] req_prev_q;

    // Per-source asserted state and previous request sample.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                asrt_q[i]     <= 1'b0;
                req_prev_q[i] <= 1'b0;
            end else begin
                asrt_q[i]     <= src_req[i] & ((asrt_q[i] & ~clr[i]) | ~req_prev_q[i]);
                req_prev_q[i] <= src_req[i];
            end
        end
    end

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((asrt_q & $past(clr)) == '0));
endmodule

// File: rtl/intc_ext_group.sv
// External level decoder: 15 virtual members, member j carrying level 15-j.
// The group changes only when the encoded level changes; level 0 clears all.
module intc_ext_group (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [3:0]                    ext_level,
    input  logic [intc_pkg::EXT_MEMBERS-1:0] clr,
    output logic [intc_pkg::EXT_MEMBERS-1:0] asrt_q
);
    localparam int M = intc_pkg::EXT_MEMBERS;

    logic [3:0] last_q;

    // Decode a level change into one asserted member; apply level-mode clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asrt_q <= '0;
            last_q <= 4'd0;
        end else begin
            last_q <= ext_level;
            if (ext_level != last_q)
                asrt_q <= (ext_level == 4'd0) ? '0 : (M'(1) << (4'd15 - ext_level));
            else
                asrt_q <= asrt_q & ~clr;
        end
    end

    assert_ext_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(asrt_q));
endmodule

// File: rtl/intc_arbiter.sv
// Priority scan: keeps the first pending input with strictly greater internal
// priority, so ties go to the lowest index. Outputs the halved 4-bit level.
module intc_arbiter #(
    parameter int NUM_IN = 23,
    parameter int IDW    = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_IN-1:0]                pend,
    input  logic [NUM_IN*intc_pkg::PW-1:0]   prio,
    output logic                             found,
    output logic [IDW-1:0]                   win_id,
    output logic [3:0]                       win_lvl
);
    localparam int PW = intc_pkg::PW;

    logic [PW-1:0] best;

    // Linear scan over all inputs.
    always_comb begin
        best   = '0;
        found  = 1'b0;
        win_id = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (pend[i] && prio[i*PW +: PW] > best) begin
                best   = prio[i*PW +: PW];
                win_id = IDW'(i);
                found  = 1'b1;
            end
        end
        win_lvl = best[PW-1:1];
    end

    assert_winner_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> pend[win_id]);
endmodule

// File: rtl/prio_intc.sv
// Top of the programmable-priority interrupt controller. Assumes state is
// registered and the offer is combinational from state, so every input change
// shows on the outputs one clock later.
module prio_intc #(
    parameter int NUM_SRC = 8,
    parameter int AW      = 4,
    parameter int IDW     = $clog2(NUM_SRC + intc_pkg::EXT_MEMBERS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [3:0]         ext_level,
    input  logic [3:0]         cpu_mask,
    input  logic               irq_ack,
    output logic               irq_valid,
    output logic [IDW-1:0]     irq_vector,
    output logic [3:0]         irq_level
);
    import intc_pkg::*;

    localparam int TOTAL = NUM_SRC + EXT_MEMBERS;

    logic                 lvl_mode;
    logic [NUM_SRC*4-1:0] prio_field;
    logic [NUM_SRC-1:0]   mask_q;
    logic [NUM_SRC-1:0]   per_asrt;
    logic [EXT_MEMBERS-1:0] ext_asrt;
    logic [TOTAL-1:0]     asrt_all;
    logic [TOTAL-1:0]     pend_all;
    logic [TOTAL*PW-1:0]  prio_all;
    logic [TOTAL-1:0]     clr_all;
    logic [3:0]           cpu_mask_q;
    logic                 found;
    logic [IDW-1:0]       win_id;
    logic [3:0]           win_lvl;

    intc_regfile #(.NUM_SRC(NUM_SRC), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lvl_mode(lvl_mode),
        .prio_field(prio_field), .mask_q(mask_q)
    );

    intc_req_track #(.NUM_SRC(NUM_SRC)) u_req (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .clr(clr_all[NUM_SRC-1:0]), .asrt_q(per_asrt)
    );

    intc_ext_group u_ext (
        .clk(clk), .rst_n(rst_n), .ext_level(ext_level),
        .clr(clr_all[TOTAL-1:NUM_SRC]), .asrt_q(ext_asrt)
    );

    assign asrt_all = {ext_asrt, per_asrt};

    // Peripheral pending needs request, mask bit and a nonzero field.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_per
        assign pend_all[s]          = per_asrt[s] & mask_q[s] & (prio_field[s*4 +: 4] != 4'd0);
        assign prio_all[s*PW +: PW] = widen_prio(prio_field[s*4 +: 4]);
    end

    // External members are always enabled and carry fixed priorities.
    for (genvar j = 0; j < EXT_MEMBERS; j++) begin : g_ext
        assign pend_all[NUM_SRC+j]            = ext_asrt[j];
        assign prio_all[(NUM_SRC+j)*PW +: PW] = ext_prio(j);
    end

    intc_arbiter #(.NUM_IN(TOTAL), .IDW(IDW)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend_all), .prio(prio_all),
        .found(found), .win_id(win_id), .win_lvl(win_lvl)
    );

    // Register the processor mask so it lines up with the other state.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_mask_q <= 4'd0;
        else        cpu_mask_q <= cpu_mask;
    end

    assign irq_valid  = found && (win_lvl > cpu_mask_q);
    assign irq_vector = win_id;
    assign irq_level  = win_lvl;

    // Level-mode clear of the accepted source.
    assign clr_all = (irq_ack && irq_valid && lvl_mode) ?
                     ({{(TOTAL-1){1'b0}}, 1'b1} << irq_vector) : '0;

    assert_valid_beats_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level > cpu_mask_q));

    assert_level_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level != 4'd0));

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid && lvl_mode && ext_level == 4'd0 && $past(ext_level) == 4'd0) |=>
        !asrt_all[$past(irq_vector)]);
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    localparam int N     = 8;
    localparam int AW    = 4;
    localparam int NPR   = (N + 3) / 4;
    localparam int TOTAL = N + 15;
    localparam int IDW   = $clog2(TOTAL);
    localparam int A_SET = NPR + 1;
    localparam int A_CLR = NPR + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] src_req = '0;
    logic [3:0] ext_level = 4'd0;
    logic [3:0] cpu_mask = 4'd0;
    logic irq_ack = 1'b0;
    logic irq_valid;
    logic [IDW-1:0] irq_vector;
    logic [3:0] irq_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit compare_on = 1'b0;

    always #2.5 clk = ~clk;

    prio_intc #(.NUM_SRC(N), .AW(AW)) u_prio_intc (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .ext_level(ext_level), .cpu_mask(cpu_mask), .irq_ack(irq_ack),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level)
    );

    // Behavioural reference state.
    int m_ctrl, m_mask, m_ext_last, m_cpu_mask;
    int m_prio [NPR];
    bit m_asrt [TOTAL];
    bit m_req_prev [N];

    function automatic int m_field(int s);
        return (m_prio[s/4] >> (12 - 4*(s%4))) & 15;
    endfunction

    function automatic int m_prio_of(int i);
        if (i < N) return m_field(i) * 2;
        return (15 - (i - N)) * 2;
    endfunction

    function automatic bit m_pend(int i);
        if (i < N) return m_asrt[i] && ((m_mask >> i) & 1) == 1 && m_field(i) != 0;
        return m_asrt[i];
    endfunction

    // Returns winner index or -1; lvl gets the 4-bit level; offer applies the mask.
    function automatic int m_pick(output int lvl, output bit offer);
        int best = 0;
        int id = -1;
        for (int i = 0; i < TOTAL; i++)
            if (m_pend(i) && m_prio_of(i) > best) begin
                best = m_prio_of(i);
                id = i;
            end
        lvl = best / 2;
        offer = (id >= 0) && (lvl > m_cpu_mask);
        return id;
    endfunction

    function automatic int m_read(int a);
        if (a == 0) return m_ctrl;
        if (a >= 1 && a <= NPR) return m_prio[a-1];
        if (a == A_SET || a == A_CLR) return m_mask;
        return 0;
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_mask = 0; m_ext_last = 0; m_cpu_mask = 0;
            for (int r = 0; r < NPR; r++) m_prio[r] = 0;
            for (int i = 0; i < TOTAL; i++) m_asrt[i] = 1'b0;
            for (int i = 0; i < N; i++) m_req_prev[i] = 1'b0;
        end else begin
            int lvl, id, clr;
            bit offer;
            id = m_pick(lvl, offer);
            clr = (irq_ack && offer && ((m_ctrl >> 21) & 1) == 1) ? id : -1;
            if (reg_wr) begin
                if (reg_addr == 0) m_ctrl = reg_wdata;
                else if (reg_addr >= 1 && reg_addr <= NPR) m_prio[reg_addr-1] = reg_wdata & 32'hFFFF;
                else if (reg_addr == A_SET) m_mask = m_mask | (reg_wdata & ((1 << N) - 1));
                else if (reg_addr == A_CLR) m_mask = m_mask & ~(reg_wdata & ((1 << N) - 1));
            end
            for (int i = 0; i < N; i++) begin
                m_asrt[i] = src_req[i] && ((m_asrt[i] && clr != i) || !m_req_prev[i]);
                m_req_prev[i] = src_req[i];
            end
            if (ext_level != m_ext_last) begin
                for (int j = 0; j < 15; j++) m_asrt[N+j] = 1'b0;
                if (ext_level != 0) m_asrt[N + 15 - ext_level] = 1'b1;
            end else if (clr >= N) begin
                m_asrt[clr] = 1'b0;
            end
            m_ext_last = ext_level;
            m_cpu_mask = cpu_mask;
        end
        compare_on = 1'b1;
    end

    // Compare outputs against the model on every falling edge (R6 R7 R8).
    always @(negedge clk) begin
        if (compare_on) begin
            int lvl, id;
            bit offer;
            id = m_pick(lvl, offer);
            checks++;
            if (irq_valid !== offer || (offer && (irq_vector !== IDW'(id) || irq_level !== 4'(lvl)))) begin
                errors++;
                $display("FAIL R6 R7 R8 model compare t=%0t: got v=%0b vec=%0d lvl=%0d expected v=%0b vec=%0d lvl=%0d",
                         $time, irq_valid, irq_vector, irq_level, offer, id, lvl);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired: got %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic write_reg(int a, logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_check(int a, logic [31:0] exp, string req);
        @(negedge clk);
        reg_addr = AW'(a);
        #1;
        checks++;
        if (reg_rdata !== exp || reg_rdata !== 32'(m_read(a))) begin
            errors++;
            $display("FAIL %s read addr %0d: got %h expected %h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic expect_irq(bit v, int vec, int lvl, string req);
        checks++;
        if (irq_valid !== v || (v && (irq_vector !== IDW'(vec) || irq_level !== 4'(lvl)))) begin
            errors++;
            $display("FAIL %s: got v=%0b vec=%0d lvl=%0d expected v=%0b vec=%0d lvl=%0d",
                     req, irq_valid, irq_vector, irq_level, v, vec, lvl);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ack_pulse();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        expect_irq(1'b0, 0, 0, "R1 reset valid");
        read_check(0, 32'h0, "R1 reset ctrl");
        read_check(A_SET, 32'h0, "R1 reset mask");

        write_reg(0, 32'hFFFF_FFFF);
        read_check(0, 32'hFFFF_FFFF, "R2 ctrl all ones");
        write_reg(0, 32'h0);
        read_check(0, 32'h0, "R2 ctrl cleared");

        write_reg(1, 32'h0000_1234);
        write_reg(2, 32'hABCD_0A0A);
        read_check(2, 32'h0000_0A0A, "R3 upper bits dropped");
        read_check(1, 32'h0000_1234, "R3 readback");

        write_reg(A_SET, 32'hFF);
        write_reg(A_CLR, 32'h01);
        read_check(A_SET, 32'hFE, "R4 set then clear");
        read_check(A_CLR, 32'hFE, "R4 clear address reads mask");

        src_req = 8'h01; step(); step();
        expect_irq(1'b0, 0, 0, "R4 masked source");
        src_req = 8'h00; step();
        src_req = 8'h10; step(); step();
        expect_irq(1'b0, 0, 0, "R5 zero field disables");
        src_req = 8'h0E; step(); step();
        expect_irq(1'b1, 3, 4, "R3 R6 nibble order highest");
        src_req = 8'hA0; step(); step();
        expect_irq(1'b1, 5, 10, "R6 tie lowest index");
        cpu_mask = 4'd10; step(); step();
        expect_irq(1'b0, 0, 0, "R7 equal mask blocks");
        cpu_mask = 4'd9; step(); step();
        expect_irq(1'b1, 5, 10, "R7 lower mask passes");
        cpu_mask = 4'd15; ext_level = 4'd15; step(); step();
        expect_irq(1'b0, 0, 0, "R7 mask 15 blocks all");
        cpu_mask = 4'd0; step(); step();
        expect_irq(1'b1, 8, 15, "R9 external level 15");
        ext_level = 4'd3; step(); step();
        expect_irq(1'b1, 5, 10, "R6 peripheral beats external 3");
        src_req = 8'h00; step(); step();
        expect_irq(1'b1, 20, 3, "R9 external member for level 3");
        ack_pulse(); step();
        expect_irq(1'b1, 20, 3, "R10 ack without level mode");
        ext_level = 4'd0; step(); step();
        expect_irq(1'b0, 0, 0, "R9 level 0 clears group");

        write_reg(0, 32'h0020_0000);
        ext_level = 4'd7; step(); step();
        expect_irq(1'b1, 16, 7, "R9 external level 7");
        ack_pulse();
        expect_irq(1'b0, 0, 0, "R10 level mode clears external");
        ext_level = 4'd0; step();
        src_req = 8'h08; step(); step();
        expect_irq(1'b1, 3, 4, "R10 peripheral before ack");
        ack_pulse();
        expect_irq(1'b0, 0, 0, "R10 level mode clears peripheral");
        step();
        expect_irq(1'b0, 0, 0, "R10 stays clear while request high");
        src_req = 8'h00; step();
        src_req = 8'h08; step(); step();
        expect_irq(1'b1, 3, 4, "R10 new rising edge reasserts");
        cpu_mask = 4'd15; step(); step();
        ack_pulse();
        cpu_mask = 4'd0; step(); step();
        expect_irq(1'b1, 3, 4, "R11 ack ignored when not valid");

        // Random phase, checked by the per-clock model compare.
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            src_req = N'($urandom);
            if (($urandom % 6) == 0) ext_level = 4'($urandom);
            cpu_mask = 4'($urandom % 12);
            irq_ack = (($urandom % 3) == 0);
            reg_wr = (($urandom % 10) == 0);
            reg_addr = AW'($urandom % (A_CLR + 1));
            reg_wdata = $urandom;
            if (reg_addr == 0) reg_wdata = (($urandom % 2) == 1) ? 32'h0020_0000 : 32'h0;
        end
        @(negedge clk);
        irq_ack = 1'b0; reg_wr = 1'b0;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule